// File: doc/BRIEF.md
# Saturating Q1.17 Reduction Stage

This block sits after a wide accumulator or adder. It turns a signed fixed-point result with many bits into an 18-bit Q1.17 word: one integer bit and seventeen fraction bits. First it removes a calibration offset at full precision. It then scales the difference right by a small amount that software selects. Next it drops the surplus fraction bits, either by truncation or by round-half-up. Last, it clamps the value into the output range. A near-zero reading minus its offset therefore stops at the range limit and does not wrap to a large code.

A small configuration port sets four things: the scale, the rounding mode, whether clamping is on, and whether the output is read as signed or unsigned. In signed mode the output covers -1.0 up to just under +1.0. In unsigned mode it covers 0 up to just under 2.0. An out-of-range result latches a sticky flag, which software reads and then clears, so it can tune the scale.

The input word carries 20 fraction bits and the output carries 17, so at least 3 bits are always dropped.

Top module: `fxr_reduce`

## Requirements
- R1: After reset:
  - `out_valid_o`, `out_data_o` and `ovf_sticky_o` are 0.
  - The configuration is scale 0, truncate, clamping on, signed mode and offset 0.
- R2: `out_valid_o` is high exactly one clock after a cycle with `in_valid_i` high. `out_data_o` holds its value while no new sample arrives.
- R3: The difference `in_data_i - cfg_offset_i` is formed from both operands read as signed 32-bit values, with no loss of range. Extreme inputs and offsets therefore never wrap.
- R4: In truncate mode (`cfg_round_i`=0) the result is the difference arithmetically shifted right by 3+`cfg_shift_i`, with `cfg_shift_i` in 0..3. This is a floor toward minus infinity.
- R5: In round mode (`cfg_round_i`=1) the value 2^(2+`cfg_shift_i`) is added to the difference before the shift. Ties therefore go upward.
- R6: In signed mode (`cfg_signed_i`=1) with clamping on, a result above 131071 gives 0x1FFFF. A result below -131072 gives 0x20000.
- R7: In unsigned mode (`cfg_signed_i`=0) with clamping on, a result above 262143 gives 0x3FFFF. A negative result gives 0.
- R8: With clamping off (`cfg_sat_en_i`=0), the low 18 bits of the result are output unchanged.
- R9: A valid sample whose result is outside the selected range sets `ovf_sticky_o` one clock later, whatever the clamp setting. The flag then stays set until it is cleared.
- R10: A pulse on `ovf_clr_i` clears the flag at the next clock edge. If an out-of-range sample is accepted in the same cycle, the flag stays set.
- R11: A configuration write (`cfg_we_i`) that coincides with `in_valid_i` is ignored. A write with `in_valid_i` low takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_shift_i | input | 2 | Extra right-shift amount, 0..3 |
| cfg_round_i | input | 1 | 1 = round half up, 0 = truncate |
| cfg_sat_en_i | input | 1 | 1 = clamp to range, 0 = wrap |
| cfg_signed_i | input | 1 | 1 = signed output range, 0 = unsigned |
| cfg_offset_i | input | 32 | Signed calibration offset |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 32 | Signed input, 20 fraction bits |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | 18 | Q1.17 result |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| ovf_sticky_o | output | 1 | Sticky out-of-range flag |

## Verification
The data result, the output valid and any new overflow flag all appear at the first rising edge after the edge that samples `in_valid_i`. A clear takes effect at the first edge after it is sampled. The bench changes inputs on falling edges and reads the outputs on the following falling edge. Each check therefore sees exactly one register stage. Configuration changes are mirrored into the bench model only when `in_valid_i` was low in the write cycle. The check for an idle cycle confirms that the data holds and the valid drops.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  localparam int SHIFT_W = 2;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;
    logic               rnd;
    logic               sat_en;
    logic               sgn;
  } fxr_mode_t;

  localparam fxr_mode_t MODE_RST = '{shift: '0, rnd: 1'b0, sat_en: 1'b1, sgn: 1'b1};
endpackage

// File: rtl/fxr_cfg.sv
module fxr_cfg
  import fxr_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            busy_i,
  input  fxr_mode_t       mode_i,
  input  logic [IN_W-1:0] offset_i,
  output fxr_mode_t       mode_o,
  output logic [IN_W-1:0] offset_o
);
  // writes accepted only when no sample is entering
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_RST;
      offset_o <= '0;
    end else if (we_i && !busy_i) begin
      mode_o   <= mode_i;
      offset_o <= offset_i;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable({mode_o, offset_o}));  // R11
endmodule

// File: rtl/fxr_scale.sv
module fxr_scale
  import fxr_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int DROP  = 3,
  parameter int EXT_W = IN_W + 2
) (
  input  logic        [IN_W-1:0]    data_i,
  input  logic        [IN_W-1:0]    offset_i,
  input  logic        [SHIFT_W-1:0] shift_i,
  input  logic                      rnd_i,
  output logic signed [EXT_W-1:0]   q_o
);
  localparam int N_SH = 1 << SHIFT_W;

  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] cand [N_SH];

  // sign-extend both operands before subtracting: no wrap at zero
  assign diff = EXT_W'($signed(data_i)) - EXT_W'($signed(offset_i));

  for (genvar g = 0; g < N_SH; g++) begin : g_amt
    localparam int AMT = DROP + g;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (AMT - 1);
    logic signed [EXT_W-1:0] sum;
    assign sum     = diff + (rnd_i ? HALF : '0);
    assign cand[g] = sum >>> AMT;
  end

  assign q_o = cand[shift_i];
endmodule

// File: rtl/fxr_sat.sv
module fxr_sat #(
  parameter int EXT_W = 34,
  parameter int OUT_W = 18
) (
  input  logic signed [EXT_W-1:0] q_i,
  input  logic                    sgn_i,
  input  logic                    sat_en_i,
  output logic        [OUT_W-1:0] data_o,
  output logic                    range_err_o
);
  localparam logic signed [EXT_W-1:0] S_HI = (EXT_W'(1) << (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] S_LO = -(EXT_W'(1) << (OUT_W - 1));
  localparam logic signed [EXT_W-1:0] U_HI = (EXT_W'(1) << OUT_W) - EXT_W'(1);

  logic signed [EXT_W-1:0] hi, lo;
  logic over, under;

  assign hi    = sgn_i ? S_HI : U_HI;
  assign lo    = sgn_i ? S_LO : '0;
  assign over  = q_i > hi;
  assign under = q_i < lo;
  assign range_err_o = over | under;

  always_comb begin
    if (sat_en_i && over)       data_o = hi[OUT_W-1:0];
    else if (sat_en_i && under) data_o = lo[OUT_W-1:0];
    else                        data_o = q_i[OUT_W-1:0];
  end
endmodule

// File: rtl/fxr_flag.sv
module fxr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);  // R9
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);  // R10
  AST_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);  // R10
endmodule

// File: rtl/fxr_reduce.sv
module fxr_reduce
  import fxr_pkg::*;
#(
  parameter int IN_W     = 32,
  parameter int IN_FRAC  = 20,
  parameter int OUT_W    = 18,
  parameter int OUT_FRAC = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SHIFT_W-1:0] cfg_shift_i,
  input  logic               cfg_round_i,
  input  logic               cfg_sat_en_i,
  input  logic               cfg_signed_i,
  input  logic [IN_W-1:0]    cfg_offset_i,
  input  logic               in_valid_i,
  input  logic [IN_W-1:0]    in_data_i,
  output logic               out_valid_o,
  output logic [OUT_W-1:0]   out_data_o,
  input  logic               ovf_clr_i,
  output logic               ovf_sticky_o
);
  localparam int DROP  = IN_FRAC - OUT_FRAC;
  localparam int EXT_W = IN_W + 2;

  fxr_mode_t               mode_d, mode_q;
  logic [IN_W-1:0]         offset_q;
  logic signed [EXT_W-1:0] q;
  logic [OUT_W-1:0]        res;
  logic                    range_err;

  assign mode_d = '{shift: cfg_shift_i, rnd: cfg_round_i,
                    sat_en: cfg_sat_en_i, sgn: cfg_signed_i};

  fxr_cfg #(.IN_W(IN_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .busy_i   (in_valid_i),
    .mode_i   (mode_d),
    .offset_i (cfg_offset_i),
    .mode_o   (mode_q),
    .offset_o (offset_q)
  );

  fxr_scale #(.IN_W(IN_W), .DROP(DROP), .EXT_W(EXT_W)) u_scale (
    .data_i   (in_data_i),
    .offset_i (offset_q),
    .shift_i  (mode_q.shift),
    .rnd_i    (mode_q.rnd),
    .q_o      (q)
  );

  fxr_sat #(.EXT_W(EXT_W), .OUT_W(OUT_W)) u_sat (
    .q_i         (q),
    .sgn_i       (mode_q.sgn),
    .sat_en_i    (mode_q.sat_en),
    .data_o      (res),
    .range_err_o (range_err)
  );

  fxr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (in_valid_i & range_err),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_sticky_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= res;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(out_data_o)));  // R2
endmodule

// File: tb/fxr_reduce_tb.sv
`timescale 1ns/1ps
module fxr_reduce_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_shift = '0;
  logic        cfg_round = 1'b0, cfg_sat_en = 1'b1, cfg_signed = 1'b1;
  logic [31:0] cfg_offset = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [17:0] out_data;
  logic        ovf_clr = 1'b0;
  logic        ovf_sticky;

  int checks = 0;
  int errors = 0;

  // bench model of configuration and flag
  int     m_sh = 0;
  bit     m_rnd = 0, m_sat = 1, m_sgn = 1;
  longint m_off = 0;
  bit     m_flag = 0;

  always #10 clk = ~clk;

  fxr_reduce u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_shift_i(cfg_shift),
    .cfg_round_i(cfg_round), .cfg_sat_en_i(cfg_sat_en), .cfg_signed_i(cfg_signed),
    .cfg_offset_i(cfg_offset), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .ovf_clr_i(ovf_clr),
    .ovf_sticky_o(ovf_sticky)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] d, output logic [17:0] y, output bit err);
    longint diff, q, hi, lo;
    int tot;
    diff = longint'($signed(d)) - m_off;
    tot  = 3 + m_sh;
    if (m_rnd) diff = diff + (longint'(1) <<< (tot - 1));
    q  = diff >>> tot;
    hi = m_sgn ? 131071 : 262143;
    lo = m_sgn ? -131072 : 0;
    err = (q > hi) || (q < lo);
    if (m_sat && q > hi)      y = 18'(hi);
    else if (m_sat && q < lo) y = 18'(lo);
    else                      y = q[17:0];
  endfunction

  task automatic write_cfg(input int sh, input bit rnd, input bit sat, input bit sgn,
                           input logic [31:0] off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_shift = 2'(sh); cfg_round = rnd; cfg_sat_en = sat;
    cfg_signed = sgn; cfg_offset = off;
    @(negedge clk);
    cfg_we = 1'b0;
    m_sh = sh; m_rnd = rnd; m_sat = sat; m_sgn = sgn; m_off = longint'($signed(off));
  endtask

  task automatic send(input logic [31:0] d, input string tag);
    logic [17:0] ey;
    bit e;
    model(d, ey, e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
    chk(tag, {14'd0, out_data}, {14'd0, ey});
    m_flag = m_flag | e;
    chk("R9 sticky", {31'd0, ovf_sticky}, {31'd0, m_flag});
  endtask

  task automatic clear_flag();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    m_flag = 0;
    chk("R10 clear", {31'd0, ovf_sticky}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] ey;
    bit e;
    logic [17:0] held;
    void'($urandom(32'd20201229));
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 data", {14'd0, out_data}, 32'd0);
    chk("R1 sticky", {31'd0, ovf_sticky}, 32'd0);
    rst_n = 1'b1;

    // defaults: shift 0, truncate, clamp, signed, offset 0
    send(32'd800, "R1 default scale");
    chk("R1 literal", {14'd0, out_data}, 32'd100);
    send(32'hFFFF_FFF7, "R4 floor negative");  // -9 -> -2
    chk("R4 literal", {14'd0, out_data}, 32'h3FFFE);

    // idle hold
    held = out_data;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R2 idle hold", {14'd0, out_data}, {14'd0, held});

    // rounding ties
    write_cfg(0, 1, 1, 1, 32'd0);
    send(32'd12, "R5 tie up");
    chk("R5 literal", {14'd0, out_data}, 32'd2);
    send(32'hFFFF_FFF4, "R5 neg tie");  // -12 -> -1
    chk("R5 neg literal", {14'd0, out_data}, 32'h3FFFF);
    write_cfg(3, 1, 1, 1, 32'd0);
    send(32'd96, "R5 shift3 tie");  // 96/64=1.5 -> 2

    // signed clamps
    write_cfg(0, 0, 1, 1, 32'd0);
    send(32'd1 << 21, "R6 pos clamp");
    chk("R6 literal", {14'd0, out_data}, 32'h1FFFF);
    clear_flag();
    send(32'hFFE0_0000, "R6 neg clamp");
    chk("R6 neg literal", {14'd0, out_data}, 32'h20000);
    clear_flag();
    send(32'd1048568, "R6 edge max");  // exactly 131071
    chk("R9 no flag at edge", {31'd0, ovf_sticky}, 32'd0);

    // unsigned, offset removal near zero
    write_cfg(0, 0, 1, 0, 32'd800);
    send(32'd720, "R7 offset clamps to zero");
    chk("R7 literal", {14'd0, out_data}, 32'd0);
    send(32'd2000000, "R7 unsigned in range");
    send(32'd3000000, "R7 unsigned top clamp");
    chk("R7 top literal", {14'd0, out_data}, 32'h3FFFF);
    clear_flag();

    // extreme offset: no wrap
    write_cfg(3, 0, 1, 1, 32'h8000_0000);
    send(32'h7FFF_FFFF, "R3 no wrap");
    chk("R3 literal", {14'd0, out_data}, 32'h1FFFF);
    clear_flag();

    // clamp disabled wraps, flag still set
    write_cfg(1, 0, 0, 1, 32'd0);
    send(32'h0040_0010, "R8 wrap");
    chk("R9 flag with clamp off", {31'd0, ovf_sticky}, 32'd1);

    // clear coinciding with overflow
    model(32'h0100_0000, ey, e);
    @(negedge clk);
    ovf_clr = 1'b1; in_valid = 1'b1; in_data = 32'h0100_0000;
    @(negedge clk);
    ovf_clr = 1'b0; in_valid = 1'b0;
    m_flag = e;
    chk("R10 set beats clear", {31'd0, ovf_sticky}, 32'd1);
    clear_flag();

    // config write during valid is ignored
    write_cfg(0, 0, 1, 1, 32'd0);
    model(32'd800, ey, e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_shift = 2'd3; cfg_round = 1'b1; cfg_signed = 1'b0;
    cfg_offset = 32'd400; in_valid = 1'b1; in_data = 32'd800;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R11 same cycle", {14'd0, out_data}, {14'd0, ey});
    send(32'd1600, "R11 old config kept");
    chk("R11 literal", {14'd0, out_data}, 32'd200);

    // random
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [31:0] d;
      if ($urandom % 8 == 0) begin
        logic [31:0] off;
        off = $urandom;
        off = $signed(off) >>> ($urandom % 4 == 0 ? 0 : 10);
        write_cfg(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), off);
      end
      if ($urandom % 16 == 0) clear_flag();
      sel = int'($urandom % 4);
      d = $urandom;
      case (sel)
        0: d = $signed(d) >>> 12;
        1: d = $signed(d) >>> 10;
        2: d = $signed(d) >>> 7;
        default: ;
      endcase
      case (m_sat ? 1 : 0)
        1: send(d, m_sgn ? "R6 random" : "R7 random");
        default: send(d, "R8 random");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule